// File: doc/BRIEF.md
# Time-Tagged Operand Snooping Station

This block is one instruction-holding station in a distributed out-of-order execution window. A shared forwarding bus carries results. Each result has a time-tag that gives its program-order position, an address that is a register number or a memory location, and a value. For every source operand, the station keeps the value that came from the closest earlier producer of that address. It decides which producer is closest by comparing time-tags alone, with no renaming.

Each operand slot snoops the bus on its own. When a held operand value changes, or the instruction's predicate input toggles, the station asks for execution again. A processing element grants the request and later returns a result. The station then broadcasts that result with its own tag and destination address. If the predicate is false, it broadcasts the instruction's prior destination value instead. The station also outputs a priority figure: its distance in tags from the oldest uncommitted instruction, where a smaller value means it is more likely to commit.

Top module: `tts_station`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `req_valid` and `out_valid` are 0.
- R2: An operand slot captures a bus result only when all of these hold: the result's address equals the slot's source address, the result's tag is strictly below the station's own tag, and either the slot holds nothing or the result's tag is strictly above the tag of the value the slot holds. Any other result leaves the slot unchanged.
- R3: Each slot applies R2 on its own, so a single broadcast can fill several slots that name the same address.
- R4: `req_valid` is high only when the station holds an instruction, every slot holds a value, the station is not waiting on a result, and since the last grant a slot value has changed or the predicate has toggled. A capture that updates the tag but carries an equal value does not raise a request.
- R5: A grant (`req_valid` and `exec_ready` high together) drops the request on the next cycle, and the request stays low until `res_valid` arrives. If the inputs change while the station waits, the request is raised again right after the result.
- R6: When a closer earlier producer replaces an operand that has already been used, the instruction is requested and broadcast again.
- R7: One cycle after `res_valid` is accepted, `out_valid` is high for exactly one cycle. `out_tag` carries the own tag and `out_addr` the destination address. `out_data` carries `res_data` if `pred_i` was 1 at acceptance, and otherwise the prior destination value.
- R8: While an instruction is held, a change of `pred_i` counts as an input change under R4.
- R9: `req_prio` equals the own tag minus `commit_tag`, modulo 2^TAG_W.
- R10: `ld_valid` installs a new instruction. It empties every slot, cancels any outstanding execution, and ignores the bus in that same cycle.
- R11: With `SUPPRESS_DUP` at its default of 0, every accepted result is broadcast, including one equal to the previous broadcast.
- R12: `req_ops` carries the held values, with operand i in bits [i*DATA_W +: DATA_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Install a new instruction |
| ld_tag | input | TAG_W | Program-order tag of the new instruction |
| ld_dst | input | ADDR_W | Destination address |
| ld_srcs | input | NUM_SRC*ADDR_W | Source addresses, slot i at [i*ADDR_W +: ADDR_W] |
| ld_prior | input | DATA_W | Prior destination value, used when the predicate is false |
| pred_i | input | 1 | Microarchitectural predicate |
| commit_tag | input | TAG_W | Tag of the oldest uncommitted instruction |
| bus_valid | input | 1 | Forwarding bus carries a result |
| bus_tag | input | TAG_W | Tag of the bus result |
| bus_addr | input | ADDR_W | Address of the bus result |
| bus_data | input | DATA_W | Value of the bus result |
| exec_ready | input | 1 | Processing element accepts the request |
| res_valid | input | 1 | Execution result returns |
| res_data | input | DATA_W | Computed result |
| req_valid | output | 1 | Execute request |
| req_ops | output | NUM_SRC*DATA_W | Operand values for execution |
| req_prio | output | TAG_W | Distance from the commit point |
| out_valid | output | 1 | Station broadcasts its result |
| out_tag | output | TAG_W | Own tag of the broadcast |
| out_addr | output | ADDR_W | Destination address of the broadcast |
| out_data | output | DATA_W | Broadcast value |

## Verification
The assertions check on every cycle that:
- a request never appears while a slot is empty;
- a grant or a load always drops the request on the next cycle;
- a broadcast only ever follows an accepted result, and never lasts two cycles.

Only the bench scenarios can show the following:
- the tag-ordering rule in action, where older, younger and unrelated producers are ignored and an equal-value refresh still moves the held tag;
- re-execution after a nearer producer arrives;
- the predicate falling back to the prior value;
- duplicate broadcasts.

// File: rtl/tts_pkg.sv
package tts_pkg;

    localparam int TTS_TAG_W   = 8;
    localparam int TTS_ADDR_W  = 8;
    localparam int TTS_DATA_W  = 16;
    localparam int TTS_NUM_SRC = 2;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_WAIT  = 2'd1,
        ST_EXEC  = 2'd2
    } stage_e;

    // True when cand is an earlier producer than own and nearer than held.
    function automatic logic tag_wins(
        input logic [31:0] cand,
        input logic [31:0] own,
        input logic [31:0] held,
        input logic        held_vld
    );
        return (cand < own) && (!held_vld || (cand > held));
    endfunction

endpackage

// File: rtl/tts_opnd_slot.sv
module tts_opnd_slot #(
    parameter int TAG_W  = tts_pkg::TTS_TAG_W,
    parameter int ADDR_W = tts_pkg::TTS_ADDR_W,
    parameter int DATA_W = tts_pkg::TTS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              arm,
    input  logic [ADDR_W-1:0] new_src,
    input  logic [TAG_W-1:0]  own_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              held_vld,
    output logic [DATA_W-1:0] held_val,
    output logic              changed
);
    logic [ADDR_W-1:0] src_q;
    logic [TAG_W-1:0]  tag_q;
    logic              take;

    always_comb begin
        take = arm && bus_valid && (bus_addr == src_q) &&
               tts_pkg::tag_wins(32'(bus_tag), 32'(own_tag), 32'(tag_q), held_vld);
        changed = take && (!held_vld || (bus_data != held_val));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q    <= '0;
            tag_q    <= '0;
            held_vld <= 1'b0;
            held_val <= '0;
        end else if (clear) begin
            src_q    <= new_src;
            tag_q    <= '0;
            held_vld <= 1'b0;
        end else if (take) begin
            tag_q    <= bus_tag;
            held_vld <= 1'b1;
            held_val <= bus_data;
        end
    end
endmodule

// File: rtl/tts_issue_ctl.sv
module tts_issue_ctl (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           all_vld,
    input  logic           chg,
    input  logic           exec_ready,
    input  logic           res_valid,
    output logic           req_valid,
    output logic           done,
    output tts_pkg::stage_e stage
);
    import tts_pkg::*;

    logic dirty;
    logic grant;

    always_comb begin
        req_valid = (stage == ST_WAIT) && all_vld && dirty;
        grant     = req_valid && exec_ready;
        done      = (stage == ST_EXEC) && res_valid && !load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= ST_EMPTY;
            dirty <= 1'b0;
        end else if (load) begin
            stage <= ST_WAIT;
            dirty <= 1'b0;
        end else begin
            case (stage)
                ST_WAIT: if (grant)     stage <= ST_EXEC;
                ST_EXEC: if (res_valid) stage <= ST_WAIT;
                default: stage <= stage;
            endcase
            if (chg)        dirty <= 1'b1;
            else if (grant) dirty <= 1'b0;
        end
    end
endmodule

// File: rtl/tts_bcast.sv
module tts_bcast #(
    parameter int TAG_W        = tts_pkg::TTS_TAG_W,
    parameter int ADDR_W       = tts_pkg::TTS_ADDR_W,
    parameter int DATA_W       = tts_pkg::TTS_DATA_W,
    parameter bit SUPPRESS_DUP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              done,
    input  logic              pred,
    input  logic [DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0] prior,
    input  logic [TAG_W-1:0]  own_tag,
    input  logic [ADDR_W-1:0] dst,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] pick;
    logic [DATA_W-1:0] last_q;
    logic              sent_q;
    logic              emit;

    always_comb begin
        pick = pred ? res_data : prior;
        emit = !SUPPRESS_DUP || !sent_q || (pick != last_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_addr  <= '0;
            out_data  <= '0;
            last_q    <= '0;
            sent_q    <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (load) begin
                sent_q <= 1'b0;
            end else if (done) begin
                if (emit) begin
                    out_valid <= 1'b1;
                    out_tag   <= own_tag;
                    out_addr  <= dst;
                    out_data  <= pick;
                end
                last_q <= pick;
                sent_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tts_station.sv
module tts_station #(
    parameter int TAG_W        = tts_pkg::TTS_TAG_W,
    parameter int ADDR_W       = tts_pkg::TTS_ADDR_W,
    parameter int DATA_W       = tts_pkg::TTS_DATA_W,
    parameter int NUM_SRC      = tts_pkg::TTS_NUM_SRC,
    parameter bit SUPPRESS_DUP = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ld_valid,
    input  logic [TAG_W-1:0]          ld_tag,
    input  logic [ADDR_W-1:0]         ld_dst,
    input  logic [NUM_SRC*ADDR_W-1:0] ld_srcs,
    input  logic [DATA_W-1:0]         ld_prior,
    input  logic                      pred_i,
    input  logic [TAG_W-1:0]          commit_tag,
    input  logic                      bus_valid,
    input  logic [TAG_W-1:0]          bus_tag,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_data,
    input  logic                      exec_ready,
    input  logic                      res_valid,
    input  logic [DATA_W-1:0]         res_data,
    output logic                      req_valid,
    output logic [NUM_SRC*DATA_W-1:0] req_ops,
    output logic [TAG_W-1:0]          req_prio,
    output logic                      out_valid,
    output logic [TAG_W-1:0]          out_tag,
    output logic [ADDR_W-1:0]         out_addr,
    output logic [DATA_W-1:0]         out_data
);
    import tts_pkg::*;

    localparam int OPS_W = NUM_SRC * DATA_W;

    logic [TAG_W-1:0]   own_tag_q;
    logic [ADDR_W-1:0]  dst_q;
    logic [DATA_W-1:0]  prior_q;
    logic               pred_q;
    stage_e             stage;
    logic               loaded;
    logic               arm;
    logic               pred_chg;
    logic               any_chg;
    logic               done;
    logic [NUM_SRC-1:0] op_vld;
    logic [NUM_SRC-1:0] op_chg;
    logic [OPS_W-1:0]   ops_flat;

    always_comb begin
        loaded   = (stage != ST_EMPTY);
        arm      = loaded && !ld_valid;
        pred_chg = arm && (pred_i != pred_q);
        any_chg  = (|op_chg) || pred_chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_tag_q <= '0;
            dst_q     <= '0;
            prior_q   <= '0;
            pred_q    <= 1'b0;
        end else begin
            pred_q <= pred_i;
            if (ld_valid) begin
                own_tag_q <= ld_tag;
                dst_q     <= ld_dst;
                prior_q   <= ld_prior;
            end
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        tts_opnd_slot #(
            .TAG_W (TAG_W),
            .ADDR_W(ADDR_W),
            .DATA_W(DATA_W)
        ) slot_i (
            .clk      (clk),
            .rst      (rst),
            .clear    (ld_valid),
            .arm      (arm),
            .new_src  (ld_srcs[g*ADDR_W +: ADDR_W]),
            .own_tag  (own_tag_q),
            .bus_valid(bus_valid),
            .bus_tag  (bus_tag),
            .bus_addr (bus_addr),
            .bus_data (bus_data),
            .held_vld (op_vld[g]),
            .held_val (ops_flat[g*DATA_W +: DATA_W]),
            .changed  (op_chg[g])
        );
    end

    tts_issue_ctl issue_i (
        .clk       (clk),
        .rst       (rst),
        .load      (ld_valid),
        .all_vld   (&op_vld),
        .chg       (any_chg),
        .exec_ready(exec_ready),
        .res_valid (res_valid),
        .req_valid (req_valid),
        .done      (done),
        .stage     (stage)
    );

    tts_bcast #(
        .TAG_W       (TAG_W),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SUPPRESS_DUP(SUPPRESS_DUP)
    ) bcast_i (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_valid),
        .done     (done),
        .pred     (pred_i),
        .res_data (res_data),
        .prior    (prior_q),
        .own_tag  (own_tag_q),
        .dst      (dst_q),
        .out_valid(out_valid),
        .out_tag  (out_tag),
        .out_addr (out_addr),
        .out_data (out_data)
    );

    assign req_ops  = ops_flat;
    assign req_prio = own_tag_q - commit_tag;
endmodule

// File: rtl/tts_station_chk.sv
module tts_station_chk #(
    parameter int NUM_SRC = tts_pkg::TTS_NUM_SRC
) (
    input logic               clk,
    input logic               rst,
    input logic               ld_valid,
    input logic               exec_ready,
    input logic               res_valid,
    input logic               req_valid,
    input logic               out_valid,
    input logic [NUM_SRC-1:0] op_vld
);
    // R4
    req_needs_ops_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (&op_vld));

    // R5
    grant_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && exec_ready) |=> !req_valid);

    // R10
    load_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> !req_valid);

    // R7
    out_follows_res_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(res_valid));

    // R7
    out_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
endmodule

bind tts_station tts_station_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ld_valid  (ld_valid),
    .exec_ready(exec_ready),
    .res_valid (res_valid),
    .req_valid (req_valid),
    .out_valid (out_valid),
    .op_vld    (op_vld)
);

// File: tb/tts_station_tb.sv
module tts_station_tb_top;
    localparam int TW = 8;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NS = 2;
    localparam bit SUP = 1'b0;

    logic clk = 1'b0;
    logic rst;
    logic ld_valid;
    logic [TW-1:0] ld_tag;
    logic [AW-1:0] ld_dst;
    logic [NS*AW-1:0] ld_srcs;
    logic [DW-1:0] ld_prior;
    logic pred_i;
    logic [TW-1:0] commit_tag;
    logic bus_valid;
    logic [TW-1:0] bus_tag;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic exec_ready;
    logic res_valid;
    logic [DW-1:0] res_data;
    logic req_valid;
    logic [NS*DW-1:0] req_ops;
    logic [TW-1:0] req_prio;
    logic out_valid;
    logic [TW-1:0] out_tag;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;

    always #4 clk = ~clk;

    tts_station dut_i (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    bit m_loaded, m_dirty, m_pend, m_predq, m_outv, m_sent;
    int m_own, m_dst, m_prior, m_outd, m_outt, m_outa, m_last;
    int m_src[NS];
    bit m_vld[NS];
    int m_otag[NS];
    int m_oval[NS];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit m_req();
        bit all = 1;
        for (int i = 0; i < NS; i++) all &= m_vld[i];
        return m_loaded && all && m_dirty && !m_pend;
    endfunction

    function automatic longint m_ops();
        longint v = 0;
        for (int i = NS - 1; i >= 0; i--) v = (v << DW) | m_oval[i];
        return v;
    endfunction

    task automatic model_edge();
        bit grant, chg, done;
        int pick;
        if (rst) begin
            m_loaded = 0; m_dirty = 0; m_pend = 0; m_predq = 0; m_outv = 0; m_sent = 0;
            for (int i = 0; i < NS; i++) m_vld[i] = 0;
            return;
        end
        grant = m_req() && exec_ready;
        done  = m_pend && res_valid && !ld_valid;
        m_outv = 0;
        if (ld_valid) begin
            m_loaded = 1; m_own = ld_tag; m_dst = ld_dst; m_prior = ld_prior;
            for (int i = 0; i < NS; i++) begin
                m_src[i] = ld_srcs[i*AW +: AW];
                m_vld[i] = 0;
            end
            m_dirty = 0; m_pend = 0; m_sent = 0;
            m_predq = pred_i;
            return;
        end
        chg = 0;
        for (int i = 0; i < NS; i++) begin
            if (m_loaded && bus_valid && int'(bus_addr) == m_src[i] &&
                int'(bus_tag) < m_own && (!m_vld[i] || int'(bus_tag) > m_otag[i])) begin
                if (!m_vld[i] || int'(bus_data) != m_oval[i]) chg = 1;
                m_vld[i] = 1; m_otag[i] = bus_tag; m_oval[i] = bus_data;
            end
        end
        if (m_loaded && pred_i != m_predq) chg = 1;
        m_predq = pred_i;
        if (done) begin
            pick = pred_i ? int'(res_data) : m_prior;
            if (!SUP || !m_sent || pick != m_last) begin
                m_outv = 1; m_outd = pick; m_outt = m_own; m_outa = m_dst;
            end
            m_last = pick; m_sent = 1;
        end
        if (grant) m_pend = 1;
        else if (done) m_pend = 0;
        if (chg) m_dirty = 1;
        else if (grant) m_dirty = 0;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        chk(req_valid == m_req(), "R4 req_valid", req_valid, m_req());
        if (m_req()) chk(req_ops == m_ops(), "R12 req_ops", req_ops, m_ops());
        if (m_loaded) chk(req_prio == TW'(m_own - int'(commit_tag)), "R9 req_prio",
                          req_prio, TW'(m_own - int'(commit_tag)));
        chk(out_valid == m_outv, "R7 out_valid", out_valid, m_outv);
        if (m_outv) begin
            chk(out_data == DW'(m_outd), "R7 out_data", out_data, m_outd);
            chk(out_tag == TW'(m_outt) && out_addr == AW'(m_outa), "R7 out_tag/addr",
                {out_tag, out_addr}, {TW'(m_outt), AW'(m_outa)});
        end
    endtask

    task automatic bus(input int t, input int a, input int d);
        bus_valid = 1; bus_tag = TW'(t); bus_addr = AW'(a); bus_data = DW'(d);
        step();
        bus_valid = 0;
    endtask

    task automatic grant_once();
        exec_ready = 1;
        step();
        exec_ready = 0;
    endtask

    task automatic result(input int d);
        res_valid = 1; res_data = DW'(d);
        step();
        res_valid = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1; ld_valid = 0; ld_tag = 0; ld_dst = 0; ld_srcs = 0; ld_prior = 0;
        pred_i = 1; commit_tag = 8'd10; bus_valid = 0; bus_tag = 0; bus_addr = 0;
        bus_data = 0; exec_ready = 0; res_valid = 0; res_data = 0;
        step(); step();
        // R1: outputs quiet in reset
        chk(!req_valid && !out_valid, "R1 reset", {req_valid, out_valid}, 0);
        rst = 0;
        step();
        chk(!req_valid && !out_valid, "R1 after reset", {req_valid, out_valid}, 0);

        // load: own tag 20, dst 5, sources 3 and 4, prior 0x0AAA
        ld_valid = 1; ld_tag = 8'd20; ld_dst = 8'd5; ld_srcs = {8'd4, 8'd3}; ld_prior = 16'h0AAA;
        step();
        ld_valid = 0;
        chk(req_prio == 8'd10, "R9 prio 20-10", req_prio, 10);

        bus(25, 3, 16'hBAD);  // R2: younger producer ignored
        bus(5, 9, 16'hBAD);   // R2: unrelated address ignored
        bus(12, 3, 16'h0011);
        chk(!req_valid, "R4 one slot empty", req_valid, 0);
        bus(8, 4, 16'h0022);
        chk(req_valid && req_ops == 32'h0022_0011, "R12 ops order", req_ops, 32'h0022_0011);
        bus(7, 3, 16'h0099);  // R2: older than held tag 12
        chk(req_ops == 32'h0022_0011, "R2 older ignored", req_ops, 32'h0022_0011);

        grant_once();
        chk(!req_valid, "R5 drop after grant", req_valid, 0);
        result(16'h0033);
        chk(out_valid && out_data == 16'h0033 && out_tag == 8'd20 && out_addr == 8'd5,
            "R7 broadcast", out_data, 16'h0033);

        // R6: nearer producer replaces used operand
        bus(15, 3, 16'h0044);
        chk(req_valid && req_ops[15:0] == 16'h0044, "R6 re-request", req_ops, 32'h0022_0044);
        grant_once();
        result(16'h0055);
        chk(out_valid && out_data == 16'h0055, "R6 rebroadcast", out_data, 16'h0055);

        bus(16, 3, 16'h0044);  // R4: same value, tag moves
        chk(!req_valid, "R4 equal value no request", req_valid, 0);
        bus(14, 3, 16'h0077);  // R2: now older than held tag 16
        chk(!req_valid, "R2 held tag advanced", req_valid, 0);

        // R8: predicate toggles
        pred_i = 0;
        step();
        chk(req_valid, "R8 predicate change", req_valid, 1);
        grant_once();
        result(16'h0066);
        chk(out_valid && out_data == 16'h0AAA, "R7 predicate false prior", out_data, 16'h0AAA);

        // R5: change during execution
        bus(9, 4, 16'h0023);
        grant_once();
        bus(10, 4, 16'h0024);
        chk(!req_valid, "R5 no request while executing", req_valid, 0);
        result(16'h0001);
        chk(req_valid && req_ops[31:16] == 16'h0024, "R5 request after result", req_ops, 32'h0024_0044);
        grant_once();
        result(16'h0002);
        chk(out_valid && out_data == 16'h0AAA, "R11 duplicate still broadcast", out_data, 16'h0AAA);

        // R10: load with bus active in same cycle
        ld_valid = 1; ld_tag = 8'd40; ld_dst = 8'd6; ld_srcs = {8'd7, 8'd7}; ld_prior = 16'h0BBB;
        commit_tag = 8'd35;
        bus_valid = 1; bus_tag = 8'd30; bus_addr = 8'd7; bus_data = 16'h0005;
        step();
        ld_valid = 0; bus_valid = 0;
        step();
        chk(!req_valid, "R10 load-cycle bus ignored", req_valid, 0);
        chk(req_prio == 8'd5, "R9 prio 40-35", req_prio, 5);

        // R3: one broadcast fills both slots
        bus(30, 7, 16'h0005);
        chk(req_valid && req_ops == 32'h0005_0005, "R3 shared address", req_ops, 32'h0005_0005);
        step();
        finish_run();
    end
endmodule